// File: doc/BRIEF.md
# Page Fault Error Code Generator

This unit sits at the end of a page-table walk. It takes the class of fault that the walk found, together with the attributes of the access, and turns them into the architectural page fault error code word. It also checks that a 64-bit linear address is canonical before any walk begins. An address that fails this check produces a general protection indication instead of a page fault.

When paging is switched off, no fault is raised and the address passes through. Outside long mode the address is first cut to 32 bits. On a real page fault, the faulting linear address is presented with one of two write strobes. One strobe loads the fault address register. The other sends the address to an alternate destination, which is used when page faults are intercepted.

A request is a single cycle with `req_valid` high. The registered response appears on the next cycle and lasts for exactly one cycle.

Top module: `pfec_unit`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. All outputs are registered.
- R2: Fault class encodings are 0 none, 1 not-present, 2 protection, 3 reserved-bit, 4 key. With paging on and the address accepted, a not-present fault sets `fault_valid` and leaves bit 0 of `err_code` clear. A protection fault sets bit 0.
- R3: A reserved-bit fault sets bit 3 and bit 0 of `err_code`.
- R4: A key fault sets bit 5 and bit 0 of `err_code`.
- R5: Access kind encodings are 0 read, 1 write, 2 fetch. On a page fault, bit 1 is set exactly for writes, and bit 2 is set exactly when `user_access` is high.
- R6: On a page fault, bit 4 is set only for fetches, and only when `nx_enable` and `pae_enable` are both high, or when `smep_enable` is high.
- R7: With paging and long mode on, the address is non-canonical when bits 63 down to 47 (down to 56 with `five_level`) are neither all zeros nor all ones. Such an address sets `gp_fault`, gives `err_code` 0, clears `fault_valid` and both strobes, and the fault class is ignored.
- R8: On a page fault, `fault_addr` carries the linear address. `alt_addr_we` is set when `pf_intercept` is high; otherwise `fault_addr_we` is set. The two strobes are never high together, and both are low whenever there is no page fault.
- R9: With paging off, there is no fault of any kind and the fault class is ignored. `bypass_perm` is 3'b111 (bit 0 read, bit 1 write, bit 2 execute). `bypass_addr` is the address cut to 32 bits outside long mode, and the full address in long mode.
- R10: With paging on, fault class none gives no fault, no general protection, `err_code` 0 and `bypass_perm` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| fault_class | input | 3 | Walk result class |
| access_kind | input | 2 | 0 read, 1 write, 2 fetch |
| user_access | input | 1 | Access made at user privilege |
| paging_on | input | 1 | Paging enabled |
| long_mode | input | 1 | Long mode active |
| five_level | input | 1 | Five-level tables in use |
| nx_enable | input | 1 | No-execute enabled |
| pae_enable | input | 1 | Physical address extension enabled |
| smep_enable | input | 1 | Supervisor execute prevention enabled |
| pf_intercept | input | 1 | Page faults are intercepted |
| lin_addr | input | VA_W | Linear address |
| rsp_valid | output | 1 | Response valid |
| fault_valid | output | 1 | Page fault raised |
| gp_fault | output | 1 | General protection raised |
| err_code | output | ERR_W | Error code word |
| fault_addr | output | VA_W | Faulting address |
| fault_addr_we | output | 1 | Load fault address register |
| alt_addr_we | output | 1 | Send address to alternate destination |
| bypass_addr | output | VA_W | Address when paging is off |
| bypass_perm | output | 3 | Permissions when paging is off |

## Verification
Every result of this block is due exactly one clock after the request cycle, because a single register stage lies between the inputs and all outputs.

The driver applies each request at a falling edge and pushes the expected response into a queue. A monitor samples at each later falling edge: whenever `rsp_valid` is high it pops the queue and compares every output field, so each comparison lands exactly one clock after its stimulus.

Single, isolated requests confirm that `rsp_valid` drops on the cycle after the response. Back-to-back requests confirm that responses are not delayed or merged.

// File: rtl/pfec_pkg.sv
package pfec_pkg;
   typedef enum logic [2:0] {
      FC_NONE    = 3'd0,
      FC_NOTPRES = 3'd1,
      FC_PROT    = 3'd2,
      FC_RSVD    = 3'd3,
      FC_KEY     = 3'd4
   } fault_class_e;

   typedef enum logic [1:0] {
      AK_READ  = 2'd0,
      AK_WRITE = 2'd1,
      AK_FETCH = 2'd2
   } access_kind_e;

   localparam int unsigned EC_P    = 0;
   localparam int unsigned EC_W    = 1;
   localparam int unsigned EC_U    = 2;
   localparam int unsigned EC_RSVD = 3;
   localparam int unsigned EC_ID   = 4;
   localparam int unsigned EC_PK   = 5;
   localparam int unsigned EC_MIN_W = 6;
endpackage

// File: rtl/pfec_canon.sv
module pfec_canon #(
   parameter int unsigned VA_W  = 64,
   parameter int unsigned TOP_A = 47,
   parameter int unsigned TOP_B = 56
) (
   input  logic [VA_W-1:0] addr,
   input  logic            use_b,
   output logic            noncanon
);
   localparam int unsigned NLVL = 2;
   logic [NLVL-1:0] bad;

   generate
      for (genvar g = 0; g < NLVL; g++) begin : g_lvl
         localparam int unsigned TOP = (g == 0) ? TOP_A : TOP_B;
         localparam int unsigned HW  = VA_W - TOP;
         logic [HW-1:0] hi;
         assign hi     = addr[VA_W-1:TOP];
         assign bad[g] = (hi != '0) && (hi != '1);
      end
   endgenerate

   assign noncanon = use_b ? bad[1] : bad[0];
endmodule

// File: rtl/pfec_build.sv
module pfec_build
   import pfec_pkg::*;
#(
   parameter int unsigned ERR_W = 16
) (
   input  logic [2:0]       fclass,
   input  logic [1:0]       akind,
   input  logic             user,
   input  logic             nxe,
   input  logic             pae,
   input  logic             smep,
   output logic             is_fault,
   output logic [ERR_W-1:0] code
);
   logic fetch_tag;

   always_comb begin
      code      = '0;
      is_fault  = 1'b0;
      fetch_tag = (akind == AK_FETCH) && ((nxe && pae) || smep);
      unique case (fclass)
         FC_NOTPRES: is_fault = 1'b1;
         FC_PROT:    begin is_fault = 1'b1; code[EC_P] = 1'b1; end
         FC_RSVD:    begin is_fault = 1'b1; code[EC_P] = 1'b1; code[EC_RSVD] = 1'b1; end
         FC_KEY:     begin is_fault = 1'b1; code[EC_P] = 1'b1; code[EC_PK] = 1'b1; end
         default:    is_fault = 1'b0;
      endcase
      if (is_fault) begin
         code[EC_W]  = (akind == AK_WRITE);
         code[EC_U]  = user;
         code[EC_ID] = fetch_tag;
      end else begin
         code = '0;
      end
   end
endmodule

// File: rtl/pfec_unit.sv
module pfec_unit
   import pfec_pkg::*;
#(
   parameter int unsigned VA_W  = 64,
   parameter int unsigned ERR_W = 16,
   parameter int unsigned TOP4  = 47,
   parameter int unsigned TOP5  = 56,
   parameter int unsigned NARROW_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       fault_class,
   input  logic [1:0]       access_kind,
   input  logic             user_access,
   input  logic             paging_on,
   input  logic             long_mode,
   input  logic             five_level,
   input  logic             nx_enable,
   input  logic             pae_enable,
   input  logic             smep_enable,
   input  logic             pf_intercept,
   input  logic [VA_W-1:0]  lin_addr,
   output logic             rsp_valid,
   output logic             fault_valid,
   output logic             gp_fault,
   output logic [ERR_W-1:0] err_code,
   output logic [VA_W-1:0]  fault_addr,
   output logic             fault_addr_we,
   output logic             alt_addr_we,
   output logic [VA_W-1:0]  bypass_addr,
   output logic [2:0]       bypass_perm
);
   localparam int unsigned PAD_W = VA_W - NARROW_W;

   initial begin
      assert (ERR_W >= EC_MIN_W) else $error("ERR_W too small");
      assert (TOP4 < TOP5 && TOP5 < VA_W) else $error("bad canonical limits");
      assert (NARROW_W < VA_W) else $error("NARROW_W must be below VA_W");
   end

   logic             noncanon;
   logic             walk_fault;
   logic [ERR_W-1:0] walk_code;

   pfec_canon #(.VA_W(VA_W), .TOP_A(TOP4), .TOP_B(TOP5)) canon_i (
      .addr     (lin_addr),
      .use_b    (five_level),
      .noncanon (noncanon)
   );

   pfec_build #(.ERR_W(ERR_W)) build_i (
      .fclass   (fault_class),
      .akind    (access_kind),
      .user     (user_access),
      .nxe      (nx_enable),
      .pae      (pae_enable),
      .smep     (smep_enable),
      .is_fault (walk_fault),
      .code     (walk_code)
   );

   logic             n_fault, n_gp, n_fwe, n_awe;
   logic [ERR_W-1:0] n_code;
   logic [VA_W-1:0]  n_faddr, n_baddr;
   logic [2:0]       n_perm;

   always_comb begin
      n_fault = 1'b0;
      n_gp    = 1'b0;
      n_fwe   = 1'b0;
      n_awe   = 1'b0;
      n_code  = '0;
      n_faddr = '0;
      n_baddr = '0;
      n_perm  = 3'b000;
      if (!paging_on) begin
         n_perm  = 3'b111;
         n_baddr = long_mode ? lin_addr : {{PAD_W{1'b0}}, lin_addr[NARROW_W-1:0]};
      end else if (long_mode && noncanon) begin
         n_gp = 1'b1;
      end else if (walk_fault) begin
         n_fault = 1'b1;
         n_code  = walk_code;
         n_faddr = lin_addr;
         n_awe   = pf_intercept;
         n_fwe   = !pf_intercept;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         fault_valid   <= 1'b0;
         gp_fault      <= 1'b0;
         err_code      <= '0;
         fault_addr    <= '0;
         fault_addr_we <= 1'b0;
         alt_addr_we   <= 1'b0;
         bypass_addr   <= '0;
         bypass_perm   <= 3'b000;
      end else begin
         rsp_valid     <= req_valid;
         fault_valid   <= req_valid & n_fault;
         gp_fault      <= req_valid & n_gp;
         err_code      <= req_valid ? n_code : '0;
         fault_addr    <= req_valid ? n_faddr : '0;
         fault_addr_we <= req_valid & n_fwe;
         alt_addr_we   <= req_valid & n_awe;
         bypass_addr   <= req_valid ? n_baddr : '0;
         bypass_perm   <= req_valid ? n_perm : 3'b000;
      end
   end
endmodule

// File: rtl/pfec_unit_chk.sv
module pfec_unit_chk #(
   parameter int unsigned VA_W  = 64,
   parameter int unsigned ERR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       access_kind,
   input logic             paging_on,
   input logic             rsp_valid,
   input logic             fault_valid,
   input logic             gp_fault,
   input logic [ERR_W-1:0] err_code,
   input logic             fault_addr_we,
   input logic             alt_addr_we
);
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R1
   AST_RSP_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R1
   AST_RSVD_HAS_P: assert property (@(posedge clk) disable iff (!rst_n)
      err_code[3] |-> err_code[0]); // R3
   AST_KEY_HAS_P: assert property (@(posedge clk) disable iff (!rst_n)
      err_code[5] |-> err_code[0]); // R4
   AST_ID_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && err_code[4]) |-> ($past(access_kind) == 2'd2)); // R6
   AST_GP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> (!fault_valid && err_code == '0 && !fault_addr_we && !alt_addr_we)); // R7
   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fault_addr_we, alt_addr_we}) && (fault_valid == (fault_addr_we | alt_addr_we))); // R8
   AST_NOPAGING_NOFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !paging_on) |=> (!fault_valid && !gp_fault)); // R9
endmodule

bind pfec_unit pfec_unit_chk #(.VA_W(VA_W), .ERR_W(ERR_W)) chk_i (.*);

// File: tb/pfec_unit_tb_top.sv
module pfec_unit_tb_top;
   localparam int VA_W = 64;
   localparam int ERR_W = 16;

   typedef struct {
      string           tag;
      logic            fv;
      logic            gp;
      logic [ERR_W-1:0] ec;
      logic [VA_W-1:0] fa;
      logic            fwe;
      logic            awe;
      logic [VA_W-1:0] ba;
      logic [2:0]      bp;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [2:0] fault_class = '0;
   logic [1:0] access_kind = '0;
   logic user_access = 0, paging_on = 0, long_mode = 0, five_level = 0;
   logic nx_enable = 0, pae_enable = 0, smep_enable = 0, pf_intercept = 0;
   logic [VA_W-1:0] lin_addr = '0;
   logic rsp_valid, fault_valid, gp_fault, fault_addr_we, alt_addr_we;
   logic [ERR_W-1:0] err_code;
   logic [VA_W-1:0] fault_addr, bypass_addr;
   logic [2:0] bypass_perm;

   int errors = 0;
   int checks = 0;
   exp_t q[$];

   always #4 clk = ~clk;

   pfec_unit dut_i (.*);

   function automatic exp_t model(string tag, logic [2:0] fc, logic [1:0] ak, logic usr,
                                  logic pg, logic lm, logic l5, logic nx, logic pa,
                                  logic sm, logic icp, logic [VA_W-1:0] a);
      exp_t e;
      int top;
      logic [VA_W-1:0] hi, ones;
      e.tag = tag; e.fv = 0; e.gp = 0; e.ec = '0; e.fa = '0;
      e.fwe = 0; e.awe = 0; e.ba = '0; e.bp = 3'b000;
      top = l5 ? 56 : 47;
      hi = a >> top;
      ones = {VA_W{1'b1}} >> top;
      if (!pg) begin
         e.bp = 3'b111;
         e.ba = lm ? a : {32'h0, a[31:0]};
      end else if (lm && hi != '0 && hi != ones) begin
         e.gp = 1;
      end else if (fc >= 3'd1 && fc <= 3'd4) begin
         e.fv = 1;
         e.ec[0] = (fc != 3'd1);
         e.ec[3] = (fc == 3'd3);
         e.ec[5] = (fc == 3'd4);
         e.ec[1] = (ak == 2'd1);
         e.ec[2] = usr;
         e.ec[4] = (ak == 2'd2) && ((nx && pa) || sm);
         e.fa = a;
         e.awe = icp;
         e.fwe = !icp;
      end
      return e;
   endfunction

   task automatic send(string tag, logic [2:0] fc, logic [1:0] ak, logic usr,
                       logic pg, logic lm, logic l5, logic nx, logic pa,
                       logic sm, logic icp, logic [VA_W-1:0] a);
      @(negedge clk);
      fault_class = fc; access_kind = ak; user_access = usr; paging_on = pg;
      long_mode = lm; five_level = l5; nx_enable = nx; pae_enable = pa;
      smep_enable = sm; pf_intercept = icp; lin_addr = a; req_valid = 1'b1;
      q.push_back(model(tag, fc, ak, usr, pg, lm, l5, nx, pa, sm, icp, a));
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         exp_t e;
         checks++;
         if (q.size() == 0) begin
            errors++;
            $display("FAIL R1: response with no request pending act=1 exp=0");
         end else begin
            e = q.pop_front();
            if (fault_valid !== e.fv || gp_fault !== e.gp || err_code !== e.ec ||
                fault_addr !== e.fa || fault_addr_we !== e.fwe || alt_addr_we !== e.awe ||
                bypass_addr !== e.ba || bypass_perm !== e.bp) begin
               errors++;
               $display("FAIL %s: act fv=%b gp=%b ec=%h fa=%h fwe=%b awe=%b ba=%h bp=%b exp fv=%b gp=%b ec=%h fa=%h fwe=%b awe=%b ba=%h bp=%b",
                        e.tag, fault_valid, gp_fault, err_code, fault_addr, fault_addr_we,
                        alt_addr_we, bypass_addr, bypass_perm, e.fv, e.gp, e.ec, e.fa,
                        e.fwe, e.awe, e.ba, e.bp);
            end
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: act=timeout exp=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || fault_valid !== 1'b0 || err_code !== '0) begin
         errors++;
         $display("FAIL R1 reset: act rsp=%b fv=%b ec=%h exp 0 0 0", rsp_valid, fault_valid, err_code);
      end
      rst_n = 1'b1;
      // R1: single request then idle, response lasts one cycle
      send("R2 notpresent", 3'd1, 2'd0, 0, 1, 0, 0, 0, 0, 0, 0, 64'h1234);
      idle();
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: rsp_valid one cycle act=%b exp=0", rsp_valid);
      end
      // back-to-back
      send("R2 protection", 3'd2, 2'd0, 0, 1, 0, 0, 0, 0, 0, 0, 64'h5000);
      send("R3 reserved", 3'd3, 2'd0, 0, 1, 0, 0, 0, 0, 0, 0, 64'h6000);
      send("R4 key", 3'd4, 2'd0, 0, 1, 1, 0, 0, 0, 0, 0, 64'h7000);
      send("R5 write user", 3'd2, 2'd1, 1, 1, 0, 0, 0, 0, 0, 0, 64'h8000);
      send("R5 read user", 3'd1, 2'd0, 1, 1, 0, 0, 0, 0, 0, 0, 64'h8004);
      send("R6 fetch nx+pae", 3'd2, 2'd2, 0, 1, 0, 0, 1, 1, 0, 0, 64'h9000);
      send("R6 fetch nx only", 3'd2, 2'd2, 0, 1, 0, 0, 1, 0, 0, 0, 64'h9004);
      send("R6 fetch smep", 3'd1, 2'd2, 1, 1, 0, 0, 0, 0, 1, 0, 64'h9008);
      send("R6 write smep", 3'd2, 2'd1, 0, 1, 0, 0, 1, 1, 1, 0, 64'h900c);
      send("R7 noncanon 4lvl", 3'd3, 2'd1, 1, 1, 1, 0, 0, 0, 0, 0, 64'h0000_8000_0000_0000);
      send("R7 canon high 4lvl", 3'd2, 2'd0, 0, 1, 1, 0, 0, 0, 0, 0, 64'hFFFF_8000_0000_1000);
      send("R7 5lvl accepts", 3'd1, 2'd0, 0, 1, 1, 1, 0, 0, 0, 0, 64'h0000_8000_0000_0000);
      send("R7 noncanon 5lvl", 3'd1, 2'd0, 0, 1, 1, 1, 0, 0, 0, 0, 64'h0100_0000_0000_0000);
      send("R7 legacy no check", 3'd1, 2'd0, 0, 1, 0, 0, 0, 0, 0, 0, 64'h0000_8000_0000_0000);
      send("R8 intercept", 3'd2, 2'd1, 0, 1, 1, 0, 0, 0, 0, 1, 64'h0000_7fff_0000_0abc);
      send("R9 off trunc", 3'd3, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 64'hdead_beef_1234_5678);
      send("R9 off long", 3'd4, 2'd2, 1, 0, 1, 0, 0, 0, 0, 1, 64'hdead_beef_1234_5678);
      send("R10 none", 3'd0, 2'd1, 1, 1, 1, 0, 1, 1, 1, 0, 64'h4000);
      idle();
      idle();
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R1: responses missing act=%0d exp=0", q.size());
      end
      finish_run();
   end
endmodule